// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a simple synchronous host port and an asynchronous static RAM of 256K words by 16 bits. It accepts one single-word read or write at a time over a request/ready handshake. It then produces the RAM pin sequence: an address, two chip selects of opposite polarity, a low-active control per byte lane, a low-active write strobe and a low-active output enable. Every pin is driven from a flop, so the sequence is free of glitches and holds steady between clock edges.

All RAM timing limits are given in nanoseconds as elaboration parameters, together with the clock period. The controller turns them into cycle counts by ceiling division. The write strobe stays low long enough to meet the pulse width, the address-to-strobe-rise setup and the data-to-strobe-rise setup. The read capture waits for the longer of the address access time and the output-enable access time. A forced quiet interval after each read lets the RAM release the data bus before the controller drives it again.

The data bus is split into an output, an output-enable and an input, ready for a pad buffer at the chip edge. Byte enables pick the lanes for both reads and writes. Lanes that are not enabled read back as zero.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset, both selects are inactive (ram_cs_n=1, ram_cs=0), both lane controls, ram_we_n and ram_oe_n are high, ram_dq_oe is 0, ready is 1 and rvalid is 0.
- R2: A write with be nonzero updates exactly the lanes whose be bit is 1 (be[0] is bits 7:0 through ram_lb_n, be[1] is bits 15:8 through ram_ub_n). The other lane of that word keeps its old contents.
- R3: ram_we_n is low only while ram_cs_n=0, ram_cs=1 and at least one lane control is low. It falls only after the selects, lane controls and driven data have been active for at least one cycle.
- R4: ram_we_n stays low for max(ceil(T_WP/T), ceil(T_AW/T), ceil(T_DW/T)) consecutive cycles, which is 5 at the default parameters. ram_addr and ram_dq_out do not change while it is low.
- R5: A write keeps ready low for one setup cycle, the strobe-low cycles and at least one recovery cycle, stretched so the total is at least ceil(T_RC/T). This is 7 cycles at the default parameters.
- R6: A read with be nonzero holds ram_oe_n low and samples the bus after max(ceil(T_AA/T), ceil(T_OE/T)) cycles (6 at defaults). rvalid then pulses for one cycle, and rdata carries the enabled lanes with the other lane as zero.
- R7: ram_dq_oe is never 1 while ram_oe_n is 0, and ram_we_n and ram_oe_n are never low together.
- R8: After each read the controller holds ram_oe_n high and the selects inactive for max(1, ceil(T_OHZ/T)) cycles before returning to idle, so the bus is released before any later drive. A read occupies ready for 8 cycles at the default parameters.
- R9: A request with be=00 is accepted without any RAM pin activity. A write of this kind changes no memory. A read of this kind returns rvalid in the cycle after acceptance with rdata=0.
- R10: A request is accepted only on a clock edge where req and ready are both 1. Its address, data and enables are captured at that edge, and host input changes while ready is low have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request |
| we | input | 1 | 1 = write, 0 = read |
| be | input | 2 | Lane enables, bit 0 = low byte, bit 1 = high byte |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| ready | output | 1 | Controller idle, a request is taken this edge |
| rdata | output | 16 | Read data, masked by lane enables |
| rvalid | output | 1 | One-cycle read completion pulse |
| ram_addr | output | ADDR_W | RAM address pins |
| ram_dq_out | output | 16 | Data toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for ram_dq_out |
| ram_dq_in | input | 16 | Data from the RAM |
| ram_cs_n | output | 1 | Low-active chip select |
| ram_cs | output | 1 | High-active chip select |
| ram_lb_n | output | 1 | Low-byte lane control, low-active |
| ram_ub_n | output | 1 | High-byte lane control, low-active |
| ram_we_n | output | 1 | Write strobe, low-active |
| ram_oe_n | output | 1 | Output enable, low-active |

## Verification
The assertions assume that reset is held for at least two clock edges, so that the two-cycle look-back on the output enable sees reset values. They also assume that host inputs are stable around the active clock edge. The bench changes every host input on the falling edge and asserts reset for several cycles before releasing it. The behavioural RAM in the bench drives ram_dq_in only while the strobe pattern qualifies a read. Otherwise it returns a fixed filler word, so a missing lane mask or an early sample shows up in rdata.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  localparam int DW    = 16;
  localparam int NLANE = 2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WSET  = 3'd1,
    ST_WLOW  = 3'd2,
    ST_WREC  = 3'd3,
    ST_RACC  = 3'd4,
    ST_RTURN = 3'd5
  } seq_st_e;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int WLOW_CYC = 5,
  parameter int REC_CYC  = 1,
  parameter int RACC_CYC = 6,
  parameter int TURN_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [NLANE-1:0]  be,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic              ready,
  output seq_st_e           st_d,
  output logic [ADDR_W-1:0] addr_nx,
  output logic [DW-1:0]     wdata_nx,
  output logic [NLANE-1:0]  be_nx,
  output logic              cap,
  output logic              null_rd
);

  localparam int CMAX = imax(imax(WLOW_CYC, REC_CYC), imax(RACC_CYC, TURN_CYC));
  localparam int CW   = imax(1, $clog2(CMAX + 1));

  seq_st_e           st_q;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     wdata_q;
  logic [NLANE-1:0]  be_q;
  logic              accept;
  logic              cnt_end;

  assign ready   = (st_q == ST_IDLE);
  assign accept  = req && ready;
  assign cnt_end = (cnt_q == '0);
  assign null_rd = accept && !we && (be == '0);
  assign cap     = (st_q == ST_RACC) && cnt_end;

  assign addr_nx  = accept ? addr  : addr_q;
  assign wdata_nx = accept ? wdata : wdata_q;
  assign be_nx    = accept ? be    : be_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept && (be != '0)) begin
          if (we) begin
            st_d  = ST_WSET;
            cnt_d = '0;
          end else begin
            st_d  = ST_RACC;
            cnt_d = CW'(RACC_CYC - 1);
          end
        end
      end
      ST_WSET: begin
        st_d  = ST_WLOW;
        cnt_d = CW'(WLOW_CYC - 1);
      end
      ST_WLOW: begin
        if (cnt_end) begin
          st_d  = ST_WREC;
          cnt_d = CW'(REC_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WREC: begin
        if (cnt_end) st_d = ST_IDLE;
        else         cnt_d = cnt_q - 1'b1;
      end
      ST_RACC: begin
        if (cnt_end) begin
          st_d  = ST_RTURN;
          cnt_d = CW'(TURN_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RTURN: begin
        if (cnt_end) st_d = ST_IDLE;
        else         cnt_d = cnt_q - 1'b1;
      end
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      addr_q  <= addr_nx;
      wdata_q <= wdata_nx;
      be_q    <= be_nx;
    end
  end

  // R9
  null_stays_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (req && ready && (be == '0)) |=> ready);

  // R10
  busy_holds_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready && !$past(ready)) |-> ($stable(addr_q) && $stable(wdata_q) && $stable(be_q)));

endmodule

// File: rtl/sram_pins.sv
`timescale 1ns/1ps
module sram_pins
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_st_e           st_d,
  input  logic [ADDR_W-1:0] addr_nx,
  input  logic [DW-1:0]     wdata_nx,
  input  logic [NLANE-1:0]  be_nx,
  input  logic              cap,
  input  logic              null_rd,
  input  logic [DW-1:0]     ram_dq_in,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DW-1:0]     ram_dq_out,
  output logic              ram_dq_oe,
  output logic              ram_cs_n,
  output logic              ram_cs,
  output logic              ram_lb_n,
  output logic              ram_ub_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [DW-1:0]     rdata,
  output logic              rvalid
);

  logic             sel_nx;
  logic             wr_nx;
  logic [NLANE-1:0] lane_on;
  logic [DW-1:0]    masked_in;

  assign sel_nx = (st_d == ST_WSET) || (st_d == ST_WLOW) ||
                  (st_d == ST_WREC) || (st_d == ST_RACC);
  assign wr_nx  = (st_d == ST_WSET) || (st_d == ST_WLOW) || (st_d == ST_WREC);

  assign lane_on = {!ram_ub_n, !ram_lb_n};

  generate
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
      assign masked_in[g*8 +: 8] = lane_on[g] ? ram_dq_in[g*8 +: 8] : 8'h00;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr   <= '0;
      ram_dq_out <= '0;
      ram_dq_oe  <= 1'b0;
      ram_cs_n   <= 1'b1;
      ram_cs     <= 1'b0;
      ram_lb_n   <= 1'b1;
      ram_ub_n   <= 1'b1;
      ram_we_n   <= 1'b1;
      ram_oe_n   <= 1'b1;
      rdata      <= '0;
      rvalid     <= 1'b0;
    end else begin
      ram_cs_n  <= !sel_nx;
      ram_cs    <= sel_nx;
      ram_lb_n  <= !(sel_nx && be_nx[0]);
      ram_ub_n  <= !(sel_nx && be_nx[1]);
      ram_we_n  <= !(st_d == ST_WLOW);
      ram_oe_n  <= !(st_d == ST_RACC);
      ram_dq_oe <= wr_nx;
      if (sel_nx) ram_addr   <= addr_nx;
      if (wr_nx)  ram_dq_out <= wdata_nx;
      rvalid <= cap || null_rd;
      if (null_rd)  rdata <= '0;
      else if (cap) rdata <= masked_in;
    end
  end

  // R3
  we_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> (!ram_cs_n && ram_cs && !(ram_lb_n && ram_ub_n)));

  // R3
  we_fall_late_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_we_n) |-> $past(!ram_cs_n && ram_cs && ram_dq_oe));

  // R4
  we_low_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!ram_we_n && !$past(ram_we_n)) |-> ($stable(ram_addr) && $stable(ram_dq_out)));

  // R7
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (rst)
    !ram_oe_n |-> !ram_dq_oe);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!ram_we_n && !ram_oe_n));

  // R8
  turnaround_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_dq_oe) |-> ($past(ram_oe_n) && $past(ram_oe_n, 2)));

  // R6
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !ram_oe_n) |=> ram_oe_n);

endmodule

// File: rtl/sram_bus_ctrl.sv
`timescale 1ns/1ps
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int CLK_NS   = 10,
  parameter int T_RC_NS  = 55,
  parameter int T_WP_NS  = 45,
  parameter int T_AW_NS  = 50,
  parameter int T_DW_NS  = 30,
  parameter int T_AA_NS  = 55,
  parameter int T_OE_NS  = 25,
  parameter int T_OHZ_NS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        be,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic              ready,
  output logic [15:0]       rdata,
  output logic              rvalid,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [15:0]       ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [15:0]       ram_dq_in,
  output logic              ram_cs_n,
  output logic              ram_cs,
  output logic              ram_lb_n,
  output logic              ram_ub_n,
  output logic              ram_we_n,
  output logic              ram_oe_n
);

  localparam int WLOW_CYC = imax(imax(cdiv(T_WP_NS, CLK_NS), cdiv(T_AW_NS, CLK_NS)),
                                 imax(1, cdiv(T_DW_NS, CLK_NS)));
  localparam int REC_CYC  = imax(1, cdiv(T_RC_NS, CLK_NS) - 1 - WLOW_CYC);
  localparam int RACC_CYC = imax(1, imax(cdiv(T_AA_NS, CLK_NS), cdiv(T_OE_NS, CLK_NS)));
  localparam int TURN_CYC = imax(1, cdiv(T_OHZ_NS, CLK_NS));

  seq_st_e           st_d;
  logic [ADDR_W-1:0] addr_nx;
  logic [DW-1:0]     wdata_nx;
  logic [NLANE-1:0]  be_nx;
  logic              cap;
  logic              null_rd;

  sram_seq #(
    .ADDR_W   (ADDR_W),
    .WLOW_CYC (WLOW_CYC),
    .REC_CYC  (REC_CYC),
    .RACC_CYC (RACC_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .we       (we),
    .be       (be),
    .addr     (addr),
    .wdata    (wdata),
    .ready    (ready),
    .st_d     (st_d),
    .addr_nx  (addr_nx),
    .wdata_nx (wdata_nx),
    .be_nx    (be_nx),
    .cap      (cap),
    .null_rd  (null_rd)
  );

  sram_pins #(
    .ADDR_W (ADDR_W)
  ) u_pins (
    .clk        (clk),
    .rst        (rst),
    .st_d       (st_d),
    .addr_nx    (addr_nx),
    .wdata_nx   (wdata_nx),
    .be_nx      (be_nx),
    .cap        (cap),
    .null_rd    (null_rd),
    .ram_dq_in  (ram_dq_in),
    .ram_addr   (ram_addr),
    .ram_dq_out (ram_dq_out),
    .ram_dq_oe  (ram_dq_oe),
    .ram_cs_n   (ram_cs_n),
    .ram_cs     (ram_cs),
    .ram_lb_n   (ram_lb_n),
    .ram_ub_n   (ram_ub_n),
    .ram_we_n   (ram_we_n),
    .ram_oe_n   (ram_oe_n),
    .rdata      (rdata),
    .rvalid     (rvalid)
  );

endmodule

// File: tb/sram_bus_ctrl_bench.sv
`timescale 1ns/1ps
module sram_bus_ctrl_bench;

  localparam int AW   = 4;
  localparam int NW   = 1 << AW;
  localparam int TCLK = 10;

  function automatic int up(input int n); return (n + TCLK - 1) / TCLK; endfunction
  function automatic int mx(input int a, input int b); return (a > b) ? a : b; endfunction

  localparam int WLOW_E  = mx(mx(up(45), up(50)), up(30));
  localparam int WBUSY_E = 1 + WLOW_E + mx(1, up(55) - 1 - WLOW_E);
  localparam int RLAT_E  = mx(up(55), up(25));
  localparam int RBUSY_E = RLAT_E + mx(1, up(20));

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [1:0]    be = 2'b00;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic          ready, rvalid;
  logic [15:0]   rdata;
  logic [AW-1:0] ram_addr;
  logic [15:0]   ram_dq_out, ram_dq_in;
  logic          ram_dq_oe, ram_cs_n, ram_cs, ram_lb_n, ram_ub_n, ram_we_n, ram_oe_n;

  int n_chk = 0;
  int n_fail = 0;
  int fight_err = 0;
  int turn_err = 0;
  int oe_hi_run = 0;
  logic oe_prev = 1'b0;

  logic [15:0] mem [NW];
  logic [15:0] shadow [NW];

  always #(TCLK/2) clk = ~clk;

  sram_bus_ctrl #(.ADDR_W(AW), .CLK_NS(TCLK)) u_sram_bus_ctrl (
    .clk(clk), .rst(rst), .req(req), .we(we), .be(be), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .rvalid(rvalid),
    .ram_addr(ram_addr), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
    .ram_dq_in(ram_dq_in), .ram_cs_n(ram_cs_n), .ram_cs(ram_cs),
    .ram_lb_n(ram_lb_n), .ram_ub_n(ram_ub_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n)
  );

  // behavioural RAM
  always_comb begin
    if (!ram_cs_n && ram_cs && ram_we_n && !ram_oe_n)
      ram_dq_in = {ram_ub_n ? 8'hEE : mem[ram_addr][15:8],
                   ram_lb_n ? 8'hEE : mem[ram_addr][7:0]};
    else
      ram_dq_in = 16'hDEAD;
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) mem[i] <= 16'h0000;
    end else if (!ram_we_n && !ram_cs_n && ram_cs && ram_dq_oe) begin
      if (!ram_lb_n) mem[ram_addr][7:0]  <= ram_dq_out[7:0];
      if (!ram_ub_n) mem[ram_addr][15:8] <= ram_dq_out[15:8];
    end
  end

  // bus monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (ram_dq_oe && !ram_oe_n) fight_err++;
      if (ram_dq_oe && !oe_prev && oe_hi_run < mx(1, up(20))) turn_err++;
      oe_hi_run = ram_oe_n ? oe_hi_run + 1 : 0;
      oe_prev   = ram_dq_oe;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] lanes(input logic [15:0] d, input logic [1:0] b);
    return {b[1] ? d[15:8] : 8'h00, b[0] ? d[7:0] : 8'h00};
  endfunction

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] b);
    int busy, wl;
    bit moved;
    while (!ready) @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk);
    req = 1'b0;
    busy = 0; wl = 0; moved = 1'b0;
    if (b == 2'b00) chk(ram_cs_n && ram_we_n && !ram_dq_oe, "R9 null write pins", ram_cs_n, 1);
    while (!ready && busy < 64) begin
      busy++;
      if (!ram_we_n) begin
        wl++;
        if (ram_addr != a || ram_dq_out != d) moved = 1'b1;
      end
      @(negedge clk);
    end
    if (b != 2'b00) begin
      chk(wl == WLOW_E, "R4 strobe width", wl, WLOW_E);
      chk(!moved, "R4 addr/data stable", moved, 0);
      chk(busy == WBUSY_E, "R5 write occupancy", busy, WBUSY_E);
      if (b[0]) shadow[a][7:0]  = d[7:0];
      if (b[1]) shadow[a][15:8] = d[15:8];
    end else begin
      chk(busy == 0 && wl == 0, "R9 null write busy", busy, 0);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [1:0] b, input string rq);
    int k, busy;
    logic [15:0] exp;
    while (!ready) @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; be = b;
    @(negedge clk);
    req = 1'b0;
    if (b == 2'b00) chk(ram_cs_n && ram_oe_n, "R9 null read pins", ram_cs_n, 1);
    k = 0;
    while (!rvalid && k < 64) begin
      k++;
      @(negedge clk);
    end
    exp = lanes(shadow[a], b);
    chk(rdata == exp, rq, rdata, exp);
    if (b != 2'b00) begin
      chk(k == RLAT_E, "R6 read latency", k, RLAT_E);
      busy = k;
      while (!ready && busy < 64) begin
        busy++;
        @(negedge clk);
      end
      chk(busy == RBUSY_E, "R8 read occupancy", busy, RBUSY_E);
    end else begin
      chk(k == 0, "R9 null read latency", k, 0);
    end
  endtask

  initial begin : watchdog
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < NW; i++) shadow[i] = 16'h0000;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ram_cs_n && !ram_cs && ram_lb_n && ram_ub_n && ram_we_n && ram_oe_n &&
        !ram_dq_oe && ready && !rvalid, "R1 idle pins", {ram_cs_n, ram_we_n, ram_oe_n}, 7);

    // full-word fill and read back: R2, R6
    for (int a = 0; a < NW; a++) do_write(AW'(a), 16'((a * 16'h3B1D) ^ 16'hC35A), 2'b11);
    for (int a = 0; a < NW; a++) do_read(AW'(a), 2'b11, "R2 full word");

    // partial-lane writes, every lane mask on read: R2, R6
    for (int a = 0; a < NW; a++) begin
      do_write(AW'(a), 16'((a * 16'h0F31) + 16'h1234), 2'((a % 3) + 1));
      do_read(AW'(a), 2'b11, "R2 lane merge");
      do_read(AW'(a), 2'b01, "R6 low lane mask");
      do_read(AW'(a), 2'b10, "R6 high lane mask");
    end

    // R9 null requests
    do_write(AW'(5), 16'hFFFF, 2'b00);
    do_read(AW'(5), 2'b11, "R9 null write no effect");
    do_read(AW'(5), 2'b00, "R9 null read zero");

    // R10 request while busy is not taken, inputs changed while busy are ignored
    while (!ready) @(negedge clk);
    req = 1'b1; we = 1'b0; addr = AW'(9); be = 2'b11;
    @(negedge clk);
    we = 1'b1; addr = AW'(7); wdata = 16'h0BAD; be = 2'b11;
    repeat (3) @(negedge clk);
    req = 1'b0;
    while (!rvalid) @(negedge clk);
    chk(rdata == shadow[9], "R10 busy inputs ignored", rdata, shadow[9]);
    do_read(AW'(7), 2'b11, "R10 no stray write");

    // R7 and R8 bus monitors over the whole run
    chk(fight_err == 0, "R7 drive while oe low", fight_err, 0);
    chk(turn_err == 0, "R8 turnaround gap", turn_err, 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule